// File: doc/BRIEF.md
# Period Sweep Unit

This block holds the 11-bit timer period of one square-wave voice. On half-frame strobes it moves that period up or down by a fraction of the programmed period and raises a mute flag when the result would leave the playable range. Software programs three byte-wide registers: a sweep control byte, the period low byte, and a byte whose low three bits carry period bits 10:8. Each write lands on the clock edge where its strobe is high.

A divider counts half-frame strobes, and a sweep step is tried each time that divider runs out. The amount of the step is the programmed (raw) period shifted right. In the downward direction, the parameter `NEG_TWOS` picks the negation style. With `NEG_TWOS=0` the unit subtracts one extra count, as on the first voice of a pair. With `NEG_TWOS=1` it subtracts exactly the shifted amount, as on the second voice. The sum is formed 16 bits wide, so that an upward overflow and a downward wrap both show up as an out-of-range target.

Top module: `sweep_unit`

## Requirements
- R1: After reset the period output is 0, mute is 0, the divider count is 0 and no reload is pending, so the first half-frame strobe is a firing strobe.
- R2: A strobe on `plo_wr` loads period bits 7:0 from `plo_data`. A strobe on `phi_wr` loads period bits 10:8 from `phi_data[2:0]` and ignores `phi_data[7:3]`. Each write shows on the outputs one cycle later, and the other period bits keep their values. The same writes also set the raw period that is used for the shift.
- R3: On a half-frame strobe with divider count 0, the unit fires. On any other strobe the count decrements. A strobe that fires, or that finds a reload pending, loads the count from control bits 6:4, so with divider value P and no control writes the unit fires once every P+1 strobes.
- R4: A control write marks a reload as pending. The next half-frame strobe loads the divider from bits 6:4 and clears the pending mark. It fires only if the count was already 0.
- R5: A firing strobe tries a sweep step only when control bit 7 (enable) is 1, the shift count in control bits 2:0 is non-zero, and the current period is at least 8. When any of these is missing, period and mute stay as they were.
- R6: The step amount is the raw period shifted right by the shift count. When control bit 3 (negate) is 0, the target is the current period plus the step amount.
- R7: When negate is 1, the target is the current period minus the step amount, minus one more when `NEG_TWOS=0`.
- R8: When the 16-bit target is 0x800 or more, including a negative result that wraps, the step sets mute to 1 and leaves the period unchanged.
- R9: When the target is below 0x800, it becomes the new period, and mute becomes 1 if that period is below 8 and 0 otherwise.
- R10: Mute changes only on a sweep step. Period writes and control writes never change mute.
- R11: When a write and a half-frame strobe arrive in the same cycle, the step uses the register values from before the write, and the bits that the write carries replace the matching bits of the step result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Write strobe for the sweep control byte |
| ctrl_data | input | 8 | Control byte: enable 7, divider 6:4, negate 3, shift 2:0 |
| plo_wr | input | 1 | Write strobe for period bits 7:0 |
| plo_data | input | 8 | Period low byte |
| phi_wr | input | 1 | Write strobe for period bits 10:8 |
| phi_data | input | 8 | Bits 2:0 carry period bits 10:8; bits 7:3 are ignored |
| half_tick | input | 1 | Half-frame strobe, one cycle wide |
| period | output | 11 | Current timer period |
| mute | output | 1 | High while the voice must be silenced |

## Verification
Every result is registered once, so a write or a half-frame strobe that is sampled at a rising edge shows on `period` and `mute` by the following falling edge, one cycle later. The divider state is not visible at the ports. It shows up only in which strobe makes the period move, so the divider and reload checks count strobes and look at the period after each one. The bench drives inputs and compares a behavioural model of both negation styles at falling edges. Its directed checks always sample one full cycle after the strobe that caused the result.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  localparam int CALC_W   = 16;
  localparam int EN_BIT   = 7;
  localparam int NEG_BIT  = 3;
  localparam int DIV_LSB  = 4;
  localparam int SHIFT_W  = 3;
  localparam int DIV_W    = 3;

  // shifted copy of the programmed period
  function automatic logic [CALC_W-1:0] sweep_delta(
    input logic [CALC_W-1:0] raw,
    input logic [SHIFT_W-1:0] sh
  );
    return raw >> sh;
  endfunction

  // candidate period; a wrap or overflow lands at or above the range limit
  function automatic logic [CALC_W-1:0] sweep_target(
    input logic [CALC_W-1:0] cur,
    input logic [CALC_W-1:0] delta,
    input logic              neg,
    input logic              twos
  );
    logic [CALC_W-1:0] addend;
    addend = neg ? (~delta + (twos ? CALC_W'(1) : CALC_W'(0))) : delta;
    return cur + addend;
  endfunction
endpackage

// File: rtl/sweep_regs.sv
module sweep_regs #(
  parameter int PERIOD_W = 11,
  parameter int LO_W     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_wr,
  input  logic [7:0]          ctrl_data,
  input  logic                plo_wr,
  input  logic [7:0]          plo_data,
  input  logic                phi_wr,
  input  logic [7:0]          phi_data,
  output logic [7:0]          ctrl_q,
  output logic [PERIOD_W-1:0] raw_q
);
  localparam int HI_W = PERIOD_W - LO_W;

  logic unused_hi;
  assign unused_hi = ^phi_data[7:HI_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      raw_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_data;
      if (plo_wr)  raw_q[LO_W-1:0] <= plo_data[LO_W-1:0];
      if (phi_wr)  raw_q[PERIOD_W-1:LO_W] <= phi_data[HI_W-1:0];
    end
  end

  AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!plo_wr && !phi_wr) |=> $stable(raw_q)); // R2
endmodule

// File: rtl/sweep_divider.sv
module sweep_divider #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_tick,
  input  logic             ctrl_wr,
  input  logic [DIV_W-1:0] div_load,
  output logic             fire_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             reload_q;
  logic             expired;

  assign expired = (cnt_q == '0);
  assign fire_o  = half_tick && expired;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= 1'b0;
    end else begin
      if (half_tick) begin
        if (expired || reload_q) cnt_q <= div_load;
        else                     cnt_q <= cnt_q - DIV_W'(1);
        reload_q <= 1'b0;
      end
      if (ctrl_wr) reload_q <= 1'b1;
    end
  end

  AST_DIV_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && !fire_o && !reload_q) |=> (cnt_q == $past(cnt_q) - DIV_W'(1))); // R3
  AST_DIV_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !half_tick |=> $stable(cnt_q)); // R3
  AST_RELOAD_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> reload_q); // R4
endmodule

// File: rtl/sweep_core.sv
module sweep_core
  import sweep_pkg::*;
#(
  parameter int PERIOD_W   = 11,
  parameter int LO_W       = 8,
  parameter int MIN_PERIOD = 8,
  parameter bit NEG_TWOS   = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic                en,
  input  logic                neg,
  input  logic [SHIFT_W-1:0]  shift,
  input  logic [PERIOD_W-1:0] raw,
  input  logic                plo_wr,
  input  logic [7:0]          plo_data,
  input  logic                phi_wr,
  input  logic [7:0]          phi_data,
  output logic [PERIOD_W-1:0] period_q,
  output logic                mute_q
);
  localparam int HI_W = PERIOD_W - LO_W;

  logic                attempt;
  logic [CALC_W-1:0]   delta;
  logic [CALC_W-1:0]   target;
  logic                over;
  logic [PERIOD_W-1:0] swept;
  logic [PERIOD_W-1:0] period_d;
  logic                mute_d;
  logic                unused_hi;

  assign unused_hi = ^phi_data[7:HI_W];

  assign attempt = fire && en && (shift != '0) && (period_q >= PERIOD_W'(MIN_PERIOD));
  assign delta   = sweep_delta(CALC_W'(raw), shift);
  assign target  = sweep_target(CALC_W'(period_q), delta, neg, NEG_TWOS);
  assign over    = |target[CALC_W-1:PERIOD_W];
  assign swept   = (attempt && !over) ? target[PERIOD_W-1:0] : period_q;

  always_comb begin
    period_d = swept;
    if (plo_wr) period_d[LO_W-1:0] = plo_data[LO_W-1:0];
    if (phi_wr) period_d[PERIOD_W-1:LO_W] = phi_data[HI_W-1:0];
    mute_d = mute_q;
    if (attempt) mute_d = over || (target < CALC_W'(MIN_PERIOD));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      mute_q   <= 1'b0;
    end else begin
      period_q <= period_d;
      mute_q   <= mute_d;
    end
  end

  AST_MUTE_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(mute_q)); // R10
  AST_PERIOD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !plo_wr && !phi_wr) |=> $stable(period_q)); // R5
  AST_OVER_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    (attempt && over) |=> mute_q); // R8
  AST_OVER_KEEPS_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (attempt && over && !plo_wr && !phi_wr) |=> $stable(period_q)); // R8
endmodule

// File: rtl/sweep_unit.sv
module sweep_unit
  import sweep_pkg::*;
#(
  parameter int PERIOD_W   = 11,
  parameter int MIN_PERIOD = 8,
  parameter bit NEG_TWOS   = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_wr,
  input  logic [7:0]          ctrl_data,
  input  logic                plo_wr,
  input  logic [7:0]          plo_data,
  input  logic                phi_wr,
  input  logic [7:0]          phi_data,
  input  logic                half_tick,
  output logic [PERIOD_W-1:0] period,
  output logic                mute
);
  localparam int LO_W = 8;

  logic [7:0]          ctrl_q;
  logic [PERIOD_W-1:0] raw_q;
  logic                sweep_fire;
  logic                sweep_en;
  logic                sweep_neg;
  logic [SHIFT_W-1:0]  sweep_shift;
  logic [DIV_W-1:0]    sweep_div;

  assign sweep_en    = ctrl_q[EN_BIT];
  assign sweep_neg   = ctrl_q[NEG_BIT];
  assign sweep_shift = ctrl_q[SHIFT_W-1:0];
  assign sweep_div   = ctrl_q[DIV_LSB +: DIV_W];

  sweep_regs #(.PERIOD_W(PERIOD_W), .LO_W(LO_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .plo_wr(plo_wr), .plo_data(plo_data),
    .phi_wr(phi_wr), .phi_data(phi_data),
    .ctrl_q(ctrl_q), .raw_q(raw_q)
  );

  sweep_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n),
    .half_tick(half_tick), .ctrl_wr(ctrl_wr),
    .div_load(sweep_div), .fire_o(sweep_fire)
  );

  sweep_core #(
    .PERIOD_W(PERIOD_W), .LO_W(LO_W),
    .MIN_PERIOD(MIN_PERIOD), .NEG_TWOS(NEG_TWOS)
  ) u_core (
    .clk(clk), .rst_n(rst_n),
    .fire(sweep_fire), .en(sweep_en), .neg(sweep_neg), .shift(sweep_shift),
    .raw(raw_q),
    .plo_wr(plo_wr), .plo_data(plo_data),
    .phi_wr(phi_wr), .phi_data(phi_data),
    .period_q(period), .mute_q(mute)
  );
endmodule

// File: tb/sim_sweep_unit.sv
module sim_sweep_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_data = '0;
  logic       plo_wr = 1'b0;
  logic [7:0] plo_data = '0;
  logic       phi_wr = 1'b0;
  logic [7:0] phi_data = '0;
  logic       half_tick = 1'b0;
  logic [10:0] per0, per1;
  logic        mute0, mute1;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sweep_unit #(.NEG_TWOS(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .plo_wr(plo_wr), .plo_data(plo_data), .phi_wr(phi_wr), .phi_data(phi_data),
    .half_tick(half_tick), .period(per0), .mute(mute0));
  sweep_unit #(.NEG_TWOS(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .plo_wr(plo_wr), .plo_data(plo_data), .phi_wr(phi_wr), .phi_data(phi_data),
    .half_tick(half_tick), .period(per1), .mute(mute1));

  // behavioural reference, index 0 = one extra count on subtract, 1 = exact subtract
  int m_cur[2], m_div[2], m_mute[2];
  bit m_rel[2];
  int m_raw, m_ctrl;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        m_cur[s] = 0; m_div[s] = 0; m_mute[s] = 0; m_rel[s] = 0;
      end
      m_raw = 0; m_ctrl = 0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        bit fire;
        int step, t;
        fire = half_tick && (m_div[s] == 0);
        if (half_tick) begin
          if (fire || m_rel[s]) m_div[s] = (m_ctrl / 16) % 8;
          else m_div[s] = m_div[s] - 1;
          m_rel[s] = 0;
        end
        if (ctrl_wr) m_rel[s] = 1;
        if (fire && (m_ctrl >= 128) && (m_ctrl % 8 != 0) && (m_cur[s] >= 8)) begin
          step = m_raw >> (m_ctrl % 8);
          if ((m_ctrl / 8) % 2 == 1) t = m_cur[s] - step - (s == 0 ? 1 : 0);
          else t = m_cur[s] + step;
          if (t < 0 || t >= 2048) m_mute[s] = 1;
          else begin
            m_cur[s] = t;
            m_mute[s] = (t < 8) ? 1 : 0;
          end
        end
        if (plo_wr) m_cur[s] = (m_cur[s] / 256) * 256 + int'(plo_data);
        if (phi_wr) m_cur[s] = (m_cur[s] % 256) + int'(phi_data % 8) * 256;
      end
      if (plo_wr) m_raw = (m_raw / 256) * 256 + int'(plo_data);
      if (phi_wr) m_raw = (m_raw % 256) + int'(phi_data % 8) * 256;
      if (ctrl_wr) m_ctrl = int'(ctrl_data);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(per0) == m_cur[0], "R6 model period u0", int'(per0), m_cur[0]);
      check(int'(per1) == m_cur[1], "R7 model period u1", int'(per1), m_cur[1]);
      check(int'(mute0) == m_mute[0], "R9 model mute u0", int'(mute0), m_mute[0]);
      check(int'(mute1) == m_mute[1], "R9 model mute u1", int'(mute1), m_mute[1]);
    end
  end

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_data = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic wr_period(input logic [7:0] lo, input logic [7:0] hi);
    @(negedge clk); plo_wr = 1'b1; plo_data = lo; phi_wr = 1'b1; phi_data = hi;
    @(negedge clk); plo_wr = 1'b0; phi_wr = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); half_tick = 1'b1;
    @(negedge clk); half_tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(per0 == 11'd0, "R1 reset period", int'(per0), 0);
    check(mute0 == 1'b0, "R1 reset mute", int'(mute0), 0);

    // R2 period writes, top bits of the high byte ignored
    wr_period(8'h40, 8'hF9);
    check(per0 == 11'd320, "R2 period write", int'(per0), 320);

    // R6 upward step; R1 first strobe fires at once
    wr_ctrl(8'h81);
    tick();
    check(per0 == 11'd480, "R1 R6 upward step", int'(per0), 480);
    check(mute0 == 1'b0, "R9 in range clears mute", int'(mute0), 0);

    // R3 divider value 2: fires on strobes 1 and 4
    wr_ctrl(8'hA1);
    tick(); check(per0 == 11'd640, "R3 strobe 1 fires", int'(per0), 640);
    tick(); check(per0 == 11'd640, "R3 strobe 2 idle", int'(per0), 640);
    tick(); check(per0 == 11'd640, "R3 strobe 3 idle", int'(per0), 640);
    tick(); check(per0 == 11'd800, "R3 strobe 4 fires", int'(per0), 800);

    // R4 control write reloads instead of counting down
    wr_ctrl(8'hA1);
    tick(); tick(); tick();
    check(per0 == 11'd800, "R4 reload delays firing", int'(per0), 800);
    tick();
    check(per0 == 11'd960, "R4 fires after reload", int'(per0), 960);

    // R5 disabled, zero shift, short period
    wr_ctrl(8'h01);
    tick(); tick();
    check(per0 == 11'd960, "R5 disabled", int'(per0), 960);
    wr_ctrl(8'h80);
    tick();
    check(per0 == 11'd960, "R5 zero shift", int'(per0), 960);
    wr_period(8'd5, 8'd0);
    wr_ctrl(8'h81);
    tick();
    check(per0 == 11'd5, "R5 period below 8", int'(per0), 5);
    check(mute0 == 1'b0, "R5 mute held", int'(mute0), 0);

    // R7 downward steps in both styles
    wr_period(8'h00, 8'h02);
    wr_ctrl(8'h89);
    tick();
    check(per0 == 11'd255, "R7 subtract with extra count", int'(per0), 255);
    check(per1 == 11'd256, "R7 exact subtract", int'(per1), 256);

    // R8 overflow mutes and holds
    wr_period(8'h00, 8'h07);
    wr_ctrl(8'h81);
    tick();
    check(mute0 == 1'b1, "R8 overflow mutes", int'(mute0), 1);
    check(per0 == 11'd1792, "R8 overflow holds period", int'(per0), 1792);
    // R10 writes leave mute alone
    wr_period(8'h00, 8'h04);
    check(mute0 == 1'b1, "R10 write keeps mute", int'(mute0), 1);
    wr_ctrl(8'h81);
    check(mute0 == 1'b1, "R10 control write keeps mute", int'(mute0), 1);
    tick();
    check(per0 == 11'd1536, "R9 in-range step", int'(per0), 1536);
    check(mute0 == 1'b0, "R9 mute cleared", int'(mute0), 0);

    // R9 result below 8 mutes
    wr_period(8'd10, 8'd0);
    wr_ctrl(8'h89);
    tick();
    check(per0 == 11'd4, "R9 small result u0", int'(per0), 4);
    check(per1 == 11'd5, "R9 small result u1", int'(per1), 5);
    check(mute0 == 1'b1 && mute1 == 1'b1, "R9 small result mutes", int'(mute0) + int'(mute1), 2);

    // R8 downward wrap
    wr_period(8'h00, 8'h04);
    tick();
    check(per0 == 11'd511, "R7 step before wrap", int'(per0), 511);
    check(mute0 == 1'b0, "R9 mute cleared again", int'(mute0), 0);
    tick();
    check(per0 == 11'd511, "R8 wrap holds period", int'(per0), 511);
    check(mute0 == 1'b1, "R8 wrap mutes", int'(mute0), 1);
    check(per1 == 11'd0, "R9 exact subtract reaches 0", int'(per1), 0);
    check(mute1 == 1'b1, "R9 zero period mutes", int'(mute1), 1);

    // R11 write and strobe in the same cycle
    wr_period(8'h00, 8'h01);
    wr_ctrl(8'h81);
    @(negedge clk); half_tick = 1'b1; plo_wr = 1'b1; plo_data = 8'h10;
    @(negedge clk); half_tick = 1'b0; plo_wr = 1'b0;
    check(per0 == 11'd272, "R11 write overrides step", int'(per0), 272);
    check(mute0 == 1'b0, "R11 mute from step", int'(mute0), 0);
    tick();
    check(per0 == 11'd408, "R11 raw took the write", int'(per0), 408);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule